// File: doc/BRIEF.md
# Guard-Round-Sticky Rounding Unit

This block finishes the rounding step of a floating-point datapath. The caller supplies a mantissa word whose two lowest bits are the guard and round bits, a separate sticky bit, the sign of the value and a two-bit rounding mode. The unit drops the two extra bits and decides from the mode whether the kept mantissa must be incremented. It then adds one, with the carry able to run through every kept bit.

Three status outputs come back with the rounded mantissa. `inexact_o` reports that bits were discarded. `rounded_up_o` reports that an increment was applied. `carry_o` reports that the increment overflowed the kept width, so the true value is exactly the next power of two. In that case the mantissa field reads zero, and any renormalisation and exponent adjustment is up to the caller. A parameter selects either a registered output stage with one cycle of latency or a purely combinational path.

Top module: `grsr_round_unit`

## Requirements
- R1: The kept mantissa is `mant_i[MANT_W-1:2]`; `mant_o` is MANT_W-2 bits wide and equals that field whenever no increment is applied.
- R2: When `mant_i[1]` (guard), `mant_i[0]` (round) and `sticky_i` are all 0, there is no increment, and `inexact_o` and `rounded_up_o` are 0.
- R3: When any of guard, round or sticky is 1, `inexact_o` is 1.
- R4: Mode 2'b00 (nearest, ties to even) increments only when guard is 1 and at least one of round, sticky or the kept LSB (`mant_i[2]`) is 1.
- R5: Mode 2'b01 (toward zero) never increments.
- R6: Mode 2'b10 (toward plus infinity) increments only when the result is inexact and `sign_i` is 0 (positive).
- R7: Mode 2'b11 (toward minus infinity) increments only when the result is inexact and `sign_i` is 1 (negative).
- R8: An increment adds one to the kept mantissa, with the carry passing through all MANT_W-2 bits, and sets `rounded_up_o`; `rounded_up_o` is never 1 without `inexact_o`.
- R9: When an increment overflows an all-ones kept mantissa, `carry_o` is 1 and `mant_o` is all zeros; otherwise `carry_o` is 0.
- R10: With REG_OUT=1, every output appears one clock after the input is sampled, `valid_o` follows `valid_i` with the same delay, and reset (`rst_ni` low) clears `valid_o` and all status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operand is valid this cycle |
| mant_i | input | MANT_W | Mantissa with guard (bit 1) and round (bit 0) below the kept field |
| sticky_i | input | 1 | OR of all bits discarded below the round bit |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 to zero, 10 to +inf, 11 to -inf |
| valid_o | output | 1 | Result is valid |
| mant_o | output | MANT_W-2 | Rounded mantissa without guard and round bits |
| carry_o | output | 1 | Increment overflowed the kept width |
| inexact_o | output | 1 | Discarded bits were non-zero |
| rounded_up_o | output | 1 | An increment was applied |

## Verification
With the default registered stage, every result is due on the rising edge after the edge that samples its operand. The driver applies an operand on a falling edge and queues the expected result. The monitor then compares outputs on the next falling edge, half a period after they settle. Because the monitor only pops an item when `valid_o` is high, an idle cycle inserted into the stream must produce no output. An output that arrives early, late or without a matching operand therefore shows up as a queue mismatch.

// File: rtl/grsr_pkg.sv
package grsr_pkg;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_TO_ZERO   = 2'b01,
        RND_TO_POS    = 2'b10,
        RND_TO_NEG    = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic guard;
        logic round;
        logic sticky;
    } grs_t;

endpackage

// File: rtl/grsr_decide.sv
module grsr_decide
    import grsr_pkg::*;
(
    input  grs_t      grs_i,
    input  logic      lsb_i,
    input  logic      sign_i,
    input  rnd_mode_e mode_i,
    output logic      inexact_o,
    output logic      bump_o
);

    logic any_lost;
    logic past_half;

    always_comb begin
        any_lost  = grs_i.guard | grs_i.round | grs_i.sticky;
        // above half, or exactly half with an odd kept LSB
        past_half = grs_i.guard & (grs_i.round | grs_i.sticky | lsb_i);
        inexact_o = any_lost;
        unique case (mode_i)
            RND_NEAR_EVEN: bump_o = past_half;
            RND_TO_ZERO:   bump_o = 1'b0;
            RND_TO_POS:    bump_o = any_lost & ~sign_i;
            RND_TO_NEG:    bump_o = any_lost &  sign_i;
            default:       bump_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/grsr_incr.sv
module grsr_incr #(
    parameter int WIDTH = 54
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] carry;

    assign carry[0] = inc_i;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        assign sum_o[gi]    = a_i[gi] ^ carry[gi];
        assign carry[gi+1]  = a_i[gi] & carry[gi];
    end

    assign cout_o = carry[WIDTH];

endmodule

// File: rtl/grsr_round_unit.sv
module grsr_round_unit
    import grsr_pkg::*;
#(
    parameter int MANT_W  = 56,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic              sign_i,
    input  logic [1:0]        mode_i,
    output logic              valid_o,
    output logic [MANT_W-3:0] mant_o,
    output logic              carry_o,
    output logic              inexact_o,
    output logic              rounded_up_o
);

    localparam int KEEP_W = MANT_W - 2;

    logic [KEEP_W-1:0] kept;
    grs_t              grs;
    logic              inexact_c;
    logic              bump_c;
    logic [KEEP_W-1:0] sum_c;
    logic              cout_c;

    assign kept = mant_i[MANT_W-1:2];
    assign grs  = '{guard: mant_i[1], round: mant_i[0], sticky: sticky_i};

    grsr_decide u_decide (
        .grs_i     (grs),
        .lsb_i     (kept[0]),
        .sign_i    (sign_i),
        .mode_i    (rnd_mode_e'(mode_i)),
        .inexact_o (inexact_c),
        .bump_o    (bump_c)
    );

    grsr_incr #(.WIDTH(KEEP_W)) u_incr (
        .a_i    (kept),
        .inc_i  (bump_c),
        .sum_o  (sum_c),
        .cout_o (cout_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                valid_o      <= 1'b0;
                mant_o       <= '0;
                carry_o      <= 1'b0;
                inexact_o    <= 1'b0;
                rounded_up_o <= 1'b0;
            end else begin
                valid_o      <= valid_i;
                mant_o       <= sum_c;
                carry_o      <= cout_c;
                inexact_o    <= inexact_c;
                rounded_up_o <= bump_c;
            end
        end
    end else begin : g_comb
        assign valid_o      = valid_i;
        assign mant_o       = sum_c;
        assign carry_o      = cout_c;
        assign inexact_o    = inexact_c;
        assign rounded_up_o = bump_c;
    end

endmodule

// File: rtl/grsr_round_chk.sv
module grsr_round_chk #(
    parameter int MANT_W  = 56,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic [MANT_W-1:0] mant_i,
    input logic              sticky_i,
    input logic              sign_i,
    input logic [1:0]        mode_i,
    input logic              valid_o,
    input logic [MANT_W-3:0] mant_o,
    input logic              carry_o,
    input logic              inexact_o,
    input logic              rounded_up_o
);

    // R8
    up_needs_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && rounded_up_o |-> inexact_o);

    // R9
    carry_wraps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && carry_o |-> rounded_up_o && (mant_o == '0));

    if (REG_OUT) begin : g_seq
        // R10
        valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i |=> valid_o);

        // R2
        exact_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && (mant_i[1:0] == 2'b00) && !sticky_i |=>
                !inexact_o && !rounded_up_o && (mant_o == $past(mant_i[MANT_W-1:2])));

        // R3
        lost_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && ((mant_i[1:0] != 2'b00) || sticky_i) |=> inexact_o);

        // R5
        to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && (mode_i == 2'b01) |=> !rounded_up_o);

        // R6
        to_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && (mode_i == 2'b10) && sign_i |=> !rounded_up_o);

        // R7
        to_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && (mode_i == 2'b11) && !sign_i |=> !rounded_up_o);
    end else begin : g_cmb
        // R10
        valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i |-> valid_o);

        // R2
        exact_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && (mant_i[1:0] == 2'b00) && !sticky_i |->
                !inexact_o && !rounded_up_o && (mant_o == mant_i[MANT_W-1:2]));

        // R3
        lost_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && ((mant_i[1:0] != 2'b00) || sticky_i) |-> inexact_o);

        // R5
        to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && (mode_i == 2'b01) |-> !rounded_up_o);

        // R6
        to_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && (mode_i == 2'b10) && sign_i |-> !rounded_up_o);

        // R7
        to_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i && (mode_i == 2'b11) && !sign_i |-> !rounded_up_o);
    end

endmodule

bind grsr_round_unit grsr_round_chk #(.MANT_W(MANT_W), .REG_OUT(REG_OUT)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .mant_i       (mant_i),
    .sticky_i     (sticky_i),
    .sign_i       (sign_i),
    .mode_i       (mode_i),
    .valid_o      (valid_o),
    .mant_o       (mant_o),
    .carry_o      (carry_o),
    .inexact_o    (inexact_o),
    .rounded_up_o (rounded_up_o)
);

// File: tb/test_grsr_round_unit.sv
module test_grsr_round_unit;

    localparam int CLK_PERIOD = 10;
    localparam int MW         = 56;
    localparam int KW         = MW - 2;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [KW-1:0] mant;
        logic          carry;
        logic          inexact;
        logic          up;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [MW-1:0] mant_i = '0;
    logic          sticky_i = 1'b0;
    logic          sign_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          valid_o;
    logic [KW-1:0] mant_o;
    logic          carry_o;
    logic          inexact_o;
    logic          rounded_up_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    grsr_round_unit #(.MANT_W(MW), .REG_OUT(1'b1)) i_grsr_round_unit (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .valid_i      (valid_i),
        .mant_i       (mant_i),
        .sticky_i     (sticky_i),
        .sign_i       (sign_i),
        .mode_i       (mode_i),
        .valid_o      (valid_o),
        .mant_o       (mant_o),
        .carry_o      (carry_o),
        .inexact_o    (inexact_o),
        .rounded_up_o (rounded_up_o)
    );

    // driver: computes expected result from the requirements and queues it
    task automatic drive(input logic [MW-1:0] m, input logic s, input logic sg,
                         input logic [1:0] md, input string tag);
        exp_t          e;
        logic [KW:0]   total;
        logic          g, r, lost, up;
        g    = m[1];
        r    = m[0];
        lost = g | r | s;
        case (md)
            2'b00:   up = g & (r | s | m[2]);
            2'b01:   up = 1'b0;
            2'b10:   up = lost & ~sg;
            default: up = lost & sg;
        endcase
        total     = {1'b0, m[MW-1:2]} + {{KW{1'b0}}, up};
        e.mant    = total[KW-1:0];
        e.carry   = total[KW];
        e.inexact = lost;
        e.up      = up;
        e.tag     = tag;
        @(negedge clk);
        sb.push_back(e);
        valid_i  = 1'b1;
        mant_i   = m;
        sticky_i = s;
        sign_i   = sg;
        mode_i   = md;
    endtask

    task automatic idle();
        @(negedge clk);
        valid_i = 1'b0;
        mant_i  = '1;
        sticky_i = 1'b1;
    endtask

    // monitor: compares one cycle after each sampled operand
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected valid_o, actual=1 expected=0");
            end else begin
                e = sb.pop_front();
                if (mant_o !== e.mant || carry_o !== e.carry ||
                    inexact_o !== e.inexact || rounded_up_o !== e.up) begin
                    errors++;
                    $display("FAIL %s: actual mant=%h c=%b ix=%b up=%b expected mant=%h c=%b ix=%b up=%b",
                             e.tag, mant_o, carry_o, inexact_o, rounded_up_o,
                             e.mant, e.carry, e.inexact, e.up);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [KW-1:0] ones;
        ones = '1;
        repeat (3) @(negedge clk);
        checks++;
        // R10: reset state
        if (valid_o !== 1'b0 || rounded_up_o !== 1'b0 || inexact_o !== 1'b0 || carry_o !== 1'b0) begin
            errors++;
            $display("FAIL R10: reset actual v=%b up=%b ix=%b c=%b expected 0000",
                     valid_o, rounded_up_o, inexact_o, carry_o);
        end
        rst_n = 1'b1;

        drive({54'h12_3456_789A_BCDE, 2'b00}, 1'b0, 1'b0, 2'b00, "R1 R2 exact");
        drive({54'h00_0000_0000_0004, 2'b10}, 1'b0, 1'b0, 2'b00, "R4 tie even stays");
        drive({54'h00_0000_0000_0005, 2'b10}, 1'b0, 1'b0, 2'b00, "R4 tie odd rounds up");
        drive({54'h00_0000_0000_0004, 2'b11}, 1'b0, 1'b0, 2'b00, "R4 above half");
        drive({54'h00_0000_0000_0004, 2'b10}, 1'b1, 1'b0, 2'b00, "R4 half plus sticky");
        drive({54'h00_0000_0000_0007, 2'b01}, 1'b1, 1'b1, 2'b00, "R3 R4 below half");
        drive({54'h00_0000_0000_0007, 2'b11}, 1'b1, 1'b0, 2'b01, "R5 to zero");
        drive({54'h00_0000_0000_0010, 2'b00}, 1'b1, 1'b0, 2'b10, "R3 R6 sticky only positive");
        drive({54'h00_0000_0000_0010, 2'b01}, 1'b0, 1'b1, 2'b10, "R6 negative no bump");
        drive({54'h00_0000_0000_0010, 2'b01}, 1'b0, 1'b1, 2'b11, "R7 negative bump");
        drive({54'h00_0000_0000_0010, 2'b10}, 1'b0, 1'b0, 2'b11, "R7 positive no bump");
        drive({54'h00_0000_0000_0020, 2'b00}, 1'b0, 1'b1, 2'b11, "R2 exact negative");
        drive({54'h00_FFFF_FFFF_FFFF, 2'b11}, 1'b0, 1'b0, 2'b00, "R8 long ripple");
        idle(); // R10: bubble must yield no output
        drive({ones, 2'b11}, 1'b0, 1'b0, 2'b00, "R9 wrap nearest");
        drive({ones, 2'b01}, 1'b0, 1'b1, 2'b11, "R9 wrap to neg");
        drive({ones, 2'b01}, 1'b0, 1'b0, 2'b01, "R5 R9 no wrap to zero");

        for (int k = 0; k < 300; k++) begin
            logic [63:0] rv;
            rv = {$urandom(), $urandom()};
            if (k % 16 == 0) rv[MW-1:2] = ones;
            drive(rv[MW-1:0], rv[60], rv[61], rv[63:62], "R8 random");
        end
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10: pending results actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule